// File: doc/BRIEF.md
# EEE Low-Power-Idle Request Controller

This block decides, separately for the transmit and the receive direction of one Ethernet port, when to ask the PHY for low-power idle (LPI) and when to give that request up. A direction enters LPI only after its path has been idle for a programmed number of clock cycles. The link must run at 100 Mb/s and energy-efficient operation must have been agreed for that direction. While a direction is in LPI, it drops a clock-enable so that idle MAC and switch logic can be gated.

A direction leaves LPI on any of three causes: traffic returns, the LPI conditions stop holding, or a software-enabled wake event fires. After leaving LPI, the direction holds its ready flag low for a programmable recovery time counted in microseconds. Frames are accepted again only when the partner and the local logic are awake. The recovery time is kept below 30 µs in total so that no frame is blocked or dropped.

All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: Each direction (index 0 transmit, index 1 receive) has its own state. Idling, permission or wake of one direction never changes `lpi_req`, `clk_en` or `ready` of the other.
- R2: `lpi_req[d]` rises on the clock edge at which `path_idle[d]` has been sampled high on `idle_cycles` consecutive edges while LPI is permitted. An `idle_cycles` of 0 acts as 1. A low sample restarts the count.
- R3: With `speed_100` low (10 Mb/s), no direction asserts `lpi_req`. A direction in LPI leaves it on the first edge that samples `speed_100` low.
- R4: With `eee_ok[d]` low, direction d never asserts `lpi_req`. Clearing it while in LPI withdraws the request on the next edge.
- R5: A direction in LPI drops `lpi_req` on the first edge that samples its `path_idle` low.
- R6: An event on `wake_evt[i]` with `wake_mask[i]` high withdraws `lpi_req` of every direction in LPI on the next edge, even with the path still idle. An event whose mask bit is low has no effect.
- R7: `ready[d]` is low while in LPI and during recovery. It rises exactly N × `TICKS_PER_US` edges after the edge on which `lpi_req[d]` fell, where N is the effective recovery time in µs. A programmed 0 counts as 1.
- R8: The recovery register reads 25 µs after reset. A pulse on `cfg_wr` loads `cfg_recov_us`, which applies from the next LPI exit.
- R9: A programmed recovery time above 29 µs is clamped to 29 µs.
- R10: `clk_en[d]` is low exactly while `lpi_req[d]` is high.
- R11: After reset, all `lpi_req` are low, all `ready` and `clk_en` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_100 | input | 1 | 1 = link at 100 Mb/s, 0 = 10 Mb/s |
| eee_ok | input | NUM_DIR | Energy-efficient mode agreed per direction |
| path_idle | input | NUM_DIR | Queue or path of the direction is empty |
| wake_evt | input | NUM_EVT | Early wake event inputs |
| wake_mask | input | NUM_EVT | Software enable per wake event |
| idle_cycles | input | IDLE_W | Idle cycles needed before LPI |
| cfg_wr | input | 1 | Write strobe for the recovery register |
| cfg_recov_us | input | 8 | Recovery time in µs to write |
| lpi_req | output | NUM_DIR | LPI request toward the PHY |
| clk_en | output | NUM_DIR | Clock enable for idle MAC/switch logic |
| ready | output | NUM_DIR | Direction may send or receive frames |

## Verification
A stuck or mis-sequenced direction state shows at once as `lpi_req`, `ready` or `clk_en` out of step on the edge after the stimulus. Examples are an LPI request at 10 Mb/s, a request that survives traffic, or a wake that leaks into the other direction. A wrong idle count appears as the request rising one edge early or late. A wrong prescaler, a wrong clamp or a wrong reset value of the recovery register only shows at the end of the recovery window. The bench therefore samples `ready` on the edge just before and the edge just at the expected end.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;

  typedef enum logic [1:0] {
    LPI_ST_ACTIVE  = 2'd0,
    LPI_ST_QUIET   = 2'd1,
    LPI_ST_RECOVER = 2'd2
  } lpi_state_e;

  localparam int RECOV_W = 8;

endpackage

// File: rtl/lpi_recov_cfg.sv
module lpi_recov_cfg
  import eee_lpi_pkg::*;
#(
  parameter int RECOV_DEFAULT_US = 25,
  parameter int RECOV_CAP_US     = 29
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [RECOV_W-1:0] wdata,
  output logic [RECOV_W-1:0] eff_us
);

  localparam logic [RECOV_W-1:0] DEF_VAL = RECOV_W'(RECOV_DEFAULT_US);
  localparam logic [RECOV_W-1:0] CAP_VAL = RECOV_W'(RECOV_CAP_US);

  logic [RECOV_W-1:0] raw_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  raw_q <= DEF_VAL;
    else if (wr) raw_q <= wdata;
  end

  // zero acts as one microsecond, large values saturate at the cap
  always_comb begin
    if (raw_q == '0)          eff_us = RECOV_W'(1);
    else if (raw_q > CAP_VAL) eff_us = CAP_VAL;
    else                      eff_us = raw_q;
  end

endmodule

// File: rtl/lpi_idle_counter.sv
module lpi_idle_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             reached
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nxt;
  logic [CNT_W:0]   lim_eff;

  always_comb begin
    cnt_nxt = {1'b0, cnt_q} + (CNT_W+1)'(1);
    lim_eff = (limit == '0) ? (CNT_W+1)'(1) : {1'b0, limit};
    reached = run && (cnt_nxt >= lim_eff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run || reached) cnt_q <= '0;
    else                      cnt_q <= cnt_nxt[CNT_W-1:0];
  end

  // R2
  idle_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt_q} < lim_eff);

endmodule

// File: rtl/lpi_recov_timer.sv
module lpi_recov_timer
  import eee_lpi_pkg::*;
#(
  parameter int TICKS_PER_US = 250
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               run,
  input  logic [RECOV_W-1:0] limit_us,
  output logic               done
);

  localparam int CYC_W = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(TICKS_PER_US - 1);

  logic [CYC_W-1:0]   cyc_q;
  logic [RECOV_W-1:0] us_q;
  logic [RECOV_W-1:0] lim_q;
  logic               us_tick;

  assign us_tick = (cyc_q == CYC_LAST);
  assign done    = run && !start && us_tick && (us_q == lim_q - RECOV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q <= '0;
      us_q  <= '0;
      lim_q <= RECOV_W'(1);
    end else if (start) begin
      cyc_q <= '0;
      us_q  <= '0;
      lim_q <= limit_us;
    end else if (run) begin
      if (us_tick) begin
        cyc_q <= '0;
        us_q  <= us_q + RECOV_W'(1);
      end else begin
        cyc_q <= cyc_q + CYC_W'(1);
      end
    end
  end

  // R9
  recov_us_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (us_q < lim_q));

  // R7
  tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q <= CYC_LAST);

endmodule

// File: rtl/lpi_dir_ctrl.sv
module lpi_dir_ctrl
  import eee_lpi_pkg::*;
#(
  parameter int IDLE_W       = 16,
  parameter int TICKS_PER_US = 250
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               speed_100,
  input  logic               eee_ok,
  input  logic               path_idle,
  input  logic               evt_hit,
  input  logic [IDLE_W-1:0]  idle_cycles,
  input  logic [RECOV_W-1:0] recov_us,
  output logic               lpi_req,
  output logic               clk_en,
  output logic               ready
);

  lpi_state_e state_q, state_d;
  logic       allowed;
  logic       idle_run;
  logic       idle_reached;
  logic       wake;
  logic       recov_start;
  logic       recov_done;

  assign allowed     = speed_100 && eee_ok;
  assign idle_run    = (state_q == LPI_ST_ACTIVE) && allowed && path_idle && !evt_hit;
  assign wake        = !allowed || !path_idle || evt_hit;
  assign recov_start = (state_q == LPI_ST_QUIET) && wake;

  lpi_idle_counter #(.CNT_W(IDLE_W)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (idle_run),
    .limit   (idle_cycles),
    .reached (idle_reached)
  );

  lpi_recov_timer #(.TICKS_PER_US(TICKS_PER_US)) u_recov (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (recov_start),
    .run      (state_q == LPI_ST_RECOVER),
    .limit_us (recov_us),
    .done     (recov_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LPI_ST_ACTIVE:  if (idle_reached) state_d = LPI_ST_QUIET;
      LPI_ST_QUIET:   if (wake)         state_d = LPI_ST_RECOVER;
      LPI_ST_RECOVER: if (recov_done)   state_d = LPI_ST_ACTIVE;
      default:                          state_d = LPI_ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= LPI_ST_ACTIVE;
    else        state_q <= state_d;
  end

  assign lpi_req = (state_q == LPI_ST_QUIET);
  assign clk_en  = (state_q != LPI_ST_QUIET);
  assign ready   = (state_q == LPI_ST_ACTIVE);

  // R3
  slow_link_no_lpi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !speed_100 |=> !lpi_req);

  // R4
  no_agreement_no_lpi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eee_ok |=> !lpi_req);

  // R5
  traffic_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lpi_req && !path_idle) |=> (!lpi_req && !ready));

  // R6
  event_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lpi_req && evt_hit) |=> !lpi_req);

  // R7
  exit_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lpi_req) |-> !ready);

  // R2
  entry_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lpi_req) |-> $past(path_idle));

endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl
  import eee_lpi_pkg::*;
#(
  parameter int NUM_DIR          = 2,
  parameter int NUM_EVT          = 2,
  parameter int IDLE_W           = 16,
  parameter int TICKS_PER_US     = 250,
  parameter int RECOV_DEFAULT_US = 25,
  parameter int RECOV_CAP_US     = 29
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               speed_100,
  input  logic [NUM_DIR-1:0] eee_ok,
  input  logic [NUM_DIR-1:0] path_idle,
  input  logic [NUM_EVT-1:0] wake_evt,
  input  logic [NUM_EVT-1:0] wake_mask,
  input  logic [IDLE_W-1:0]  idle_cycles,
  input  logic               cfg_wr,
  input  logic [7:0]         cfg_recov_us,
  output logic [NUM_DIR-1:0] lpi_req,
  output logic [NUM_DIR-1:0] clk_en,
  output logic [NUM_DIR-1:0] ready
);

  logic [RECOV_W-1:0] recov_eff;
  logic               evt_hit;

  assign evt_hit = |(wake_evt & wake_mask);

  lpi_recov_cfg #(
    .RECOV_DEFAULT_US (RECOV_DEFAULT_US),
    .RECOV_CAP_US     (RECOV_CAP_US)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .wdata  (cfg_recov_us),
    .eff_us (recov_eff)
  );

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    lpi_dir_ctrl #(
      .IDLE_W       (IDLE_W),
      .TICKS_PER_US (TICKS_PER_US)
    ) u_dir (
      .clk         (clk),
      .rst_n       (rst_n),
      .speed_100   (speed_100),
      .eee_ok      (eee_ok[d]),
      .path_idle   (path_idle[d]),
      .evt_hit     (evt_hit),
      .idle_cycles (idle_cycles),
      .recov_us    (recov_eff),
      .lpi_req     (lpi_req[d]),
      .clk_en      (clk_en[d]),
      .ready       (ready[d])
    );
  end

endmodule

// File: tb/tb_eee_lpi_ctrl.sv
module tb_eee_lpi_ctrl;

  localparam int TPU = 250;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       speed_100;
  logic [1:0] eee_ok;
  logic [1:0] path_idle;
  logic [1:0] wake_evt;
  logic [1:0] wake_mask;
  logic [15:0] idle_cycles;
  logic       cfg_wr;
  logic [7:0] cfg_recov_us;
  logic [1:0] lpi_req;
  logic [1:0] clk_en;
  logic [1:0] ready;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  eee_lpi_ctrl #(.TICKS_PER_US(TPU)) dut (
    .clk (clk), .rst_n (rst_n), .speed_100 (speed_100), .eee_ok (eee_ok),
    .path_idle (path_idle), .wake_evt (wake_evt), .wake_mask (wake_mask),
    .idle_cycles (idle_cycles), .cfg_wr (cfg_wr), .cfg_recov_us (cfg_recov_us),
    .lpi_req (lpi_req), .clk_en (clk_en), .ready (ready)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_recov(input logic [7:0] v);
    cfg_wr = 1'b1; cfg_recov_us = v;
    step(1);
    cfg_wr = 1'b0;
  endtask

  // entered at a negedge with lpi_req[d] high; releases the path and times ready
  task automatic check_recovery(input int d, input int us, input string req);
    path_idle[d] = 1'b0;
    step(1);
    chk("R5", "lpi_req after traffic", lpi_req[d], 0);
    chk("R7", "ready right after exit", ready[d], 0);
    step(us * TPU - 1);
    chk(req, "ready one edge before end", ready[d], 0);
    step(1);
    chk(req, "ready at end of recovery", ready[d], 1);
  endtask

  task automatic t_reset();
    chk("R11", "lpi_req", lpi_req, 0);
    chk("R11", "ready", ready, 3);
    chk("R11", "clk_en", clk_en, 3);
  endtask

  task automatic t_entry_default();
    idle_cycles = 16'd6;
    path_idle[0] = 1'b1;
    step(5);
    chk("R2", "lpi_req before count", lpi_req[0], 0);
    step(1);
    chk("R2", "lpi_req at count", lpi_req[0], 1);
    chk("R10", "clk_en in lpi", clk_en[0], 0);
    chk("R7", "ready in lpi", ready[0], 0);
    chk("R1", "other direction lpi", lpi_req[1], 0);
    chk("R1", "other direction ready", ready[1], 1);
    check_recovery(0, 25, "R8");
    chk("R10", "clk_en after wake", clk_en[0], 1);
  endtask

  task automatic t_gap_and_zero_recov();
    path_idle[0] = 1'b1;
    step(4);
    path_idle[0] = 1'b0;
    step(1);
    path_idle[0] = 1'b1;
    step(5);
    chk("R2", "count restarted after gap", lpi_req[0], 0);
    step(1);
    chk("R2", "lpi after full count", lpi_req[0], 1);
    write_recov(8'd0);
    check_recovery(0, 1, "R7");
  endtask

  task automatic t_idle_zero();
    idle_cycles = 16'd0;
    path_idle[1] = 1'b1;
    step(1);
    chk("R2", "zero idle count acts as one", lpi_req[1], 1);
    chk("R1", "tx unaffected", lpi_req[0], 0);
    check_recovery(1, 1, "R7");
    idle_cycles = 16'd6;
  endtask

  task automatic t_speed();
    speed_100 = 1'b0;
    path_idle = 2'b11;
    step(20);
    chk("R3", "no lpi at 10M", lpi_req, 0);
    speed_100 = 1'b1;
    step(6);
    chk("R3", "lpi at 100M", lpi_req, 3);
    chk("R10", "both clocks gated", clk_en, 0);
    speed_100 = 1'b0;
    step(1);
    chk("R3", "speed drop exits", lpi_req, 0);
    chk("R7", "not ready in recovery", ready, 0);
    step(TPU);
    chk("R3", "stays awake at 10M", ready, 3);
    speed_100 = 1'b1;
    path_idle = 2'b00;
    step(1);
  endtask

  task automatic t_eee();
    eee_ok = 2'b10;
    path_idle = 2'b11;
    step(6);
    chk("R4", "only agreed direction idles", lpi_req, 2);
    chk("R1", "tx ready kept", ready[0], 1);
    eee_ok = 2'b00;
    step(1);
    chk("R4", "agreement loss exits", lpi_req, 0);
    path_idle = 2'b00;
    step(TPU);
    chk("R4", "ready after recovery", ready, 3);
    eee_ok = 2'b11;
  endtask

  task automatic t_events();
    wake_mask = 2'b01;
    path_idle = 2'b11;
    step(6);
    chk("R6", "both in lpi", lpi_req, 3);
    wake_evt = 2'b10;
    step(1);
    wake_evt = 2'b00;
    chk("R6", "masked event ignored", lpi_req, 3);
    wake_evt = 2'b01;
    step(1);
    wake_evt = 2'b00;
    chk("R6", "enabled event exits", lpi_req, 0);
    step(TPU - 1);
    chk("R6", "ready held during recovery", ready, 0);
    step(1);
    chk("R6", "ready after recovery", ready, 3);
    step(5);
    chk("R2", "recount after event", lpi_req, 0);
    step(1);
    chk("R2", "re-entry after event", lpi_req, 3);
    path_idle = 2'b00;
    step(1);
    step(TPU);
    chk("R5", "awake after traffic", ready, 3);
    wake_mask = 2'b00;
  endtask

  task automatic t_program_and_cap();
    write_recov(8'd3);
    path_idle[0] = 1'b1;
    step(6);
    chk("R8", "lpi before programmed wake", lpi_req[0], 1);
    check_recovery(0, 3, "R8");
    write_recov(8'd200);
    path_idle[1] = 1'b1;
    step(6);
    chk("R9", "lpi before capped wake", lpi_req[1], 1);
    check_recovery(1, 29, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; speed_100 = 1'b1; eee_ok = 2'b11; path_idle = 2'b00;
    wake_evt = 2'b00; wake_mask = 2'b00; idle_cycles = 16'd6;
    cfg_wr = 1'b0; cfg_recov_us = 8'd0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_entry_default();
    t_gap_and_zero_recov();
    t_idle_zero();
    t_speed();
    t_eee();
    t_events();
    t_program_and_cap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule